// File: doc/BRIEF.md
# Fixed-Point Recursive Least-Squares Update Engine

This block adapts a four-tap real-valued FIR weight vector with the recursive least-squares rule. It keeps the inverse-correlation estimate P (a 4x4 matrix) and the weight vector w in its own registers. For every pair of input vector u and desired sample d it performs one full update: it scales P by the inverse forgetting factor, forms the gain vector, computes the a priori error from the old weights, corrects the weights, and finally downdates P. All of this runs on one shared multiplier and adder, sequenced by a state machine, so an update takes a fixed number of cycles.

A controller first pulses `init_i` to load P with the regularisation value on its diagonal and to clear the weights. It then presents u and d with a `start_i` pulse, waits for `done_o`, and reads the new weights and the error. The inverse forgetting factor and the initial diagonal value are configuration inputs. The one division each update needs (the reciprocal of the gain denominator) is done by a small internal shift-subtract divider.

Top module: `rls_engine`

## Requirements
- R1: After reset `busy_o` and `done_o` are 0, `w_o` is all zero and `alpha_o` is zero.
- R2: A cycle with `init_i` high while the engine is idle loads every diagonal element of P with `dlt_inv_i`, every off-diagonal element with zero, and clears `w_o` and `alpha_o` to zero from the next cycle on.
- R3: Every value is a 16-bit two's-complement number with 10 fractional bits (1.0 is 0x0400). Vector element i of `u_i` and `w_o` occupies bits [16i+15:16i]. A product of two values is the signed 32-bit product arithmetically shifted right by 10, keeping its low 16 bits. All sums and differences wrap modulo 2^16 and nothing saturates.
- R4: One update works in this order, using the rule of R3 for every product. First each P element is replaced by lambda_inv·P. Then x = P·u (the scaled P), and s = uᵀx. From these, k_i = x_i·r, and alpha = d − wᵀu uses the old weights. Next w_i += k_i·alpha. Last, P_ij −= k_i·x_j. Dot products accumulate their 16-bit terms with wrap.
- R5: r is the reciprocal of den = 1.0 + s, given as 2^20 divided by |den|, truncated toward zero, kept to its low 16 bits and negated when den is negative. When den is zero, r is 0x7FFF.
- R6: A `start_i` pulse while idle makes `busy_o` high from the next cycle. `done_o` is high for exactly one cycle, after all P and w writes, and the engine is idle on the following cycle.
- R7: `start_i` while busy (including the `done_o` cycle) is ignored. The running update uses the u and d captured at its own start, and no second update follows.
- R8: While the engine is idle and `init_i` is low, `w_o` and `alpha_o` hold their values.
- R9: When `init_i` and `start_i` are high in the same idle cycle, the initialisation is performed and the start request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Load P with the diagonal value and clear w and alpha (idle only) |
| start_i | input | 1 | Begin one update with the present u_i and d_i (idle only) |
| lam_inv_i | input | 16 | Inverse forgetting factor, Q5.10, captured at start |
| dlt_inv_i | input | 16 | Initial diagonal value of P, Q5.10, used at init |
| u_i | input | 64 | Input vector, four Q5.10 elements |
| d_i | input | 16 | Desired sample, Q5.10 |
| busy_o | output | 1 | An update is in progress |
| done_o | output | 1 | One-cycle pulse at the end of an update |
| w_o | output | 64 | Weight vector, four Q5.10 elements |
| alpha_o | output | 16 | A priori error of the latest update |

## Verification
The properties assume that `start_i` and `init_i` are driven to known levels, synchronously to the clock, and that reset is released away from the rising edge. Under those conditions, the rules on busy, done and holding follow from the control inputs alone. The stimulus changes every input only on the falling edge and releases reset there. It raises `start_i` during busy only at points inside an update, so that the ignored requests of R7 are exercised without breaking these assumptions. The numeric values of u, d and the configuration are unconstrained, because wrap-around arithmetic defines a result for every pattern, including a zero gain denominator.

// File: rtl/rls_pkg.sv
package rls_pkg;
  localparam int RLS_W    = 16;
  localparam int RLS_FRAC = 10;
  localparam int RLS_TAPS = 4;

  typedef enum logic [3:0] {
    RS_IDLE,
    RS_SCALE,
    RS_XVEC,
    RS_UDOT,
    RS_DGO,
    RS_DWAIT,
    RS_GAIN,
    RS_ERR,
    RS_WUPD,
    RS_PUPD,
    RS_DONE
  } rls_state_e;
endpackage

// File: rtl/rls_mac.sv
module rls_mac #(
  parameter int W    = 16,
  parameter int FRAC = 10
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o
);
  logic signed [2*W-1:0] full;
  logic        [W-1:0]   prod;

  assign full  = $signed(a_i) * $signed(b_i);
  assign prod  = W'(full >>> FRAC);
  assign res_o = sub_i ? (c_i - prod) : (c_i + prod);
endmodule

// File: rtl/rls_recip.sv
module rls_recip #(
  parameter int W    = 16,
  parameter int FRAC = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_i,
  input  logic [W-1:0] den_i,
  output logic         vld_o,
  output logic [W-1:0] q_o
);
  localparam int NB  = 2 * FRAC + 1;
  localparam int BCW = $clog2(NB);
  localparam int DW  = W + 1;
  localparam logic [W-1:0] MAXPOS = {1'b0, {(W-1){1'b1}}};

  logic           run_q;
  logic [BCW-1:0] bcnt_q;
  logic [DW-1:0]  rem_q;
  logic [DW-1:0]  dvs_q;
  logic [W-1:0]   quo_q;
  logic           neg_q;
  logic           zero_q;
  logic           vld_q;
  logic [W-1:0]   q_q;

  logic [DW:0]    rem_sh;
  logic           ge;
  logic [DW-1:0]  rem_d;
  logic [W-1:0]   quo_d;
  logic [W-1:0]   res_d;
  logic [DW-1:0]  dvs_in;

  always_comb begin
    dvs_in = den_i[W-1] ? (DW'(0) - {den_i[W-1], den_i}) : {1'b0, den_i};
    rem_sh = {rem_q, (bcnt_q == BCW'(NB - 1))};
    ge     = (rem_sh >= {1'b0, dvs_q});
    rem_d  = ge ? DW'(rem_sh - {1'b0, dvs_q}) : DW'(rem_sh);
    quo_d  = W'({quo_q, ge});
    if (zero_q)      res_d = MAXPOS;
    else if (neg_q)  res_d = W'(0) - quo_d;
    else             res_d = quo_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      bcnt_q <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      quo_q  <= '0;
      neg_q  <= 1'b0;
      zero_q <= 1'b0;
      vld_q  <= 1'b0;
      q_q    <= '0;
    end else begin
      vld_q <= 1'b0;
      if (go_i) begin
        run_q  <= 1'b1;
        bcnt_q <= BCW'(NB - 1);
        rem_q  <= '0;
        quo_q  <= '0;
        dvs_q  <= dvs_in;
        neg_q  <= den_i[W-1];
        zero_q <= (den_i == '0);
      end else if (run_q) begin
        rem_q  <= rem_d;
        quo_q  <= quo_d;
        bcnt_q <= bcnt_q - BCW'(1);
        if (bcnt_q == '0) begin
          run_q <= 1'b0;
          vld_q <= 1'b1;
          q_q   <= res_d;
        end
      end
    end
  end

  assign vld_o = vld_q;
  assign q_o   = q_q;
endmodule

// File: rtl/rls_engine.sv
module rls_engine
  import rls_pkg::*;
#(
  parameter int TAPS = RLS_TAPS,
  parameter int W    = RLS_W,
  parameter int FRAC = RLS_FRAC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              start_i,
  input  logic [W-1:0]      lam_inv_i,
  input  logic [W-1:0]      dlt_inv_i,
  input  logic [TAPS*W-1:0] u_i,
  input  logic [W-1:0]      d_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [TAPS*W-1:0] w_o,
  output logic [W-1:0]      alpha_o
);
  localparam int NP = TAPS * TAPS;
  localparam int IW = $clog2(TAPS);
  localparam int CW = 2 * IW;
  localparam logic [W-1:0] ONE_FX = W'(1 << FRAC);

  rls_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  logic [W-1:0] p_q [NP];
  logic [W-1:0] x_q [TAPS];
  logic [W-1:0] k_q [TAPS];
  logic [W-1:0] w_q [TAPS];
  logic [W-1:0] u_q [TAPS];
  logic [W-1:0] d_q, lam_q, acc_q, alpha_q, recip_q;

  logic [IW-1:0] row, col;
  logic          last_col, last_all;

  logic [W-1:0] mac_a, mac_b, mac_c, mac_res;
  logic         mac_sub;
  logic         p_we, x_we, k_we, w_we, acc_we, alpha_we, recip_we, init_we, cap_we;
  logic [IW-1:0] v_wi;
  logic [W-1:0] alpha_d;
  logic         div_go, div_vld;
  logic [W-1:0] div_q, den;

  assign row      = cnt_q[CW-1:IW];
  assign col      = cnt_q[IW-1:0];
  assign last_col = (col == IW'(TAPS - 1));
  assign last_all = (cnt_q == CW'(NP - 1));
  assign den      = acc_q + ONE_FX;

  rls_mac #(.W(W), .FRAC(FRAC)) u_mac (
    .a_i   (mac_a),
    .b_i   (mac_b),
    .c_i   (mac_c),
    .sub_i (mac_sub),
    .res_o (mac_res)
  );

  rls_recip #(.W(W), .FRAC(FRAC)) u_recip (
    .clk   (clk),
    .rst_n (rst_n),
    .go_i  (div_go),
    .den_i (den),
    .vld_o (div_vld),
    .q_o   (div_q)
  );

  // next-state and datapath control
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    mac_a    = '0;
    mac_b    = '0;
    mac_c    = '0;
    mac_sub  = 1'b0;
    p_we     = 1'b0;
    x_we     = 1'b0;
    k_we     = 1'b0;
    w_we     = 1'b0;
    v_wi     = col;
    acc_we   = 1'b0;
    alpha_we = 1'b0;
    alpha_d  = '0;
    recip_we = 1'b0;
    init_we  = 1'b0;
    cap_we   = 1'b0;
    div_go   = 1'b0;
    unique case (state_q)
      RS_IDLE: begin
        if (init_i) begin
          init_we = 1'b1;
        end else if (start_i) begin
          cap_we  = 1'b1;
          cnt_d   = '0;
          state_d = RS_SCALE;
        end
      end
      RS_SCALE: begin
        mac_a = lam_q;
        mac_b = p_q[cnt_q];
        p_we  = 1'b1;
        cnt_d = cnt_q + CW'(1);
        if (last_all) state_d = RS_XVEC;
      end
      RS_XVEC: begin
        mac_a  = p_q[cnt_q];
        mac_b  = u_q[col];
        mac_c  = (col == '0) ? '0 : acc_q;
        acc_we = 1'b1;
        x_we   = last_col;
        v_wi   = row;
        cnt_d  = cnt_q + CW'(1);
        if (last_all) state_d = RS_UDOT;
      end
      RS_UDOT: begin
        mac_a  = u_q[col];
        mac_b  = x_q[col];
        mac_c  = (col == '0) ? '0 : acc_q;
        acc_we = 1'b1;
        cnt_d  = cnt_q + CW'(1);
        if (last_col) begin
          cnt_d   = '0;
          state_d = RS_DGO;
        end
      end
      RS_DGO: begin
        div_go  = 1'b1;
        state_d = RS_DWAIT;
      end
      RS_DWAIT: begin
        if (div_vld) begin
          recip_we = 1'b1;
          state_d  = RS_GAIN;
        end
      end
      RS_GAIN: begin
        mac_a = x_q[col];
        mac_b = recip_q;
        k_we  = 1'b1;
        cnt_d = cnt_q + CW'(1);
        if (last_col) begin
          cnt_d   = '0;
          state_d = RS_ERR;
        end
      end
      RS_ERR: begin
        mac_a  = w_q[col];
        mac_b  = u_q[col];
        mac_c  = (col == '0) ? '0 : acc_q;
        acc_we = 1'b1;
        cnt_d  = cnt_q + CW'(1);
        if (last_col) begin
          alpha_we = 1'b1;
          alpha_d  = d_q - mac_res;
          cnt_d    = '0;
          state_d  = RS_WUPD;
        end
      end
      RS_WUPD: begin
        mac_a = k_q[col];
        mac_b = alpha_q;
        mac_c = w_q[col];
        w_we  = 1'b1;
        cnt_d = cnt_q + CW'(1);
        if (last_col) begin
          cnt_d   = '0;
          state_d = RS_PUPD;
        end
      end
      RS_PUPD: begin
        mac_a   = k_q[row];
        mac_b   = x_q[col];
        mac_c   = p_q[cnt_q];
        mac_sub = 1'b1;
        p_we    = 1'b1;
        cnt_d   = cnt_q + CW'(1);
        if (last_all) state_d = RS_DONE;
      end
      RS_DONE: begin
        state_d = RS_IDLE;
      end
      default: state_d = RS_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // datapath registers, each with its own enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) p_q[i] <= '0;
      for (int i = 0; i < TAPS; i++) begin
        x_q[i] <= '0;
        k_q[i] <= '0;
        w_q[i] <= '0;
        u_q[i] <= '0;
      end
      d_q     <= '0;
      lam_q   <= '0;
      acc_q   <= '0;
      alpha_q <= '0;
      recip_q <= '0;
    end else begin
      if (init_we) begin
        for (int i = 0; i < NP; i++)
          p_q[i] <= ((i / TAPS) == (i % TAPS)) ? dlt_inv_i : '0;
        for (int i = 0; i < TAPS; i++) w_q[i] <= '0;
        alpha_q <= '0;
      end else begin
        if (p_we)     p_q[cnt_q] <= mac_res;
        if (w_we)     w_q[v_wi]  <= mac_res;
        if (alpha_we) alpha_q    <= alpha_d;
      end
      if (cap_we) begin
        for (int i = 0; i < TAPS; i++) u_q[i] <= u_i[i*W +: W];
        d_q   <= d_i;
        lam_q <= lam_inv_i;
      end
      if (x_we)     x_q[v_wi] <= mac_res;
      if (k_we)     k_q[v_wi] <= mac_res;
      if (acc_we)   acc_q     <= mac_res;
      if (recip_we) recip_q   <= div_q;
    end
  end

  generate
    for (genvar g = 0; g < TAPS; g++) begin : g_wout
      assign w_o[g*W +: W] = w_q[g];
    end
  endgenerate

  assign busy_o  = (state_q != RS_IDLE);
  assign done_o  = (state_q == RS_DONE);
  assign alpha_o = alpha_q;
endmodule

// File: rtl/rls_engine_chk.sv
module rls_engine_chk #(
  parameter int TAPS = 4,
  parameter int W    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_i,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [TAPS*W-1:0] w_o,
  input logic [W-1:0]      alpha_o
);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  assert_busy_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(start_i) && !$past(init_i)));

  assert_no_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  assert_no_rerun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !init_i) |=> ($stable(w_o) && $stable(alpha_o)));

  assert_init_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && init_i) |=> ((w_o == '0) && (alpha_o == '0) && !busy_o));
endmodule

bind rls_engine rls_engine_chk #(.TAPS(TAPS), .W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .init_i  (init_i),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .w_o     (w_o),
  .alpha_o (alpha_o)
);

// File: tb/tb_rls_engine.sv
module tb_rls_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        init_i, start_i;
  logic [15:0] lam_inv_i, dlt_inv_i, d_i;
  logic [63:0] u_i;
  logic        busy_o, done_o;
  logic [63:0] w_o;
  logic [15:0] alpha_o;

  int n_chk;
  int n_err;

  logic [15:0] mp [16];
  logic [15:0] mw [4];
  logic [31:0] seed;

  rls_engine dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_i    (init_i),
    .start_i   (start_i),
    .lam_inv_i (lam_inv_i),
    .dlt_inv_i (dlt_inv_i),
    .u_i       (u_i),
    .d_i       (d_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .w_o       (w_o),
    .alpha_o   (alpha_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not finish, act=hung exp=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  function automatic logic [15:0] fm(input logic [15:0] a, input logic [15:0] b);
    logic signed [31:0] p;
    p = $signed(a) * $signed(b);
    p = p >>> 10;
    return p[15:0];
  endfunction

  function automatic logic [15:0] rcp(input logic [15:0] den);
    int unsigned mag;
    int unsigned q;
    logic [15:0] r;
    if (den == 16'h0000) return 16'h7FFF;
    mag = den[15] ? (32'h10000 - {16'h0, den}) : {16'h0, den};
    q = (32'd1 << 20) / mag;
    r = q[15:0];
    if (den[15]) r = 16'h0000 - r;
    return r;
  endfunction

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_init(input logic [15:0] dlt, input logic with_start);
    dlt_inv_i = dlt;
    init_i    = 1'b1;
    start_i   = with_start;
    @(posedge clk);
    @(negedge clk);
    init_i  = 1'b0;
    start_i = 1'b0;
    for (int i = 0; i < 16; i++) mp[i] = ((i / 4) == (i % 4)) ? dlt : 16'h0000;
    for (int i = 0; i < 4; i++) mw[i] = 16'h0000;
    // R2 / R9: cleared outputs, and no update was started
    chk("R2 w0 after init", w_o[15:0], 16'h0000);
    chk("R2 alpha after init", alpha_o, 16'h0000);
    chk("R9 busy after init", {15'h0, busy_o}, 16'h0000);
  endtask

  // reference update per R4/R5; returns expected alpha
  task automatic model(input logic [63:0] uv, input logic [15:0] dv, input logic [15:0] lam,
                       output logic [15:0] al);
    logic [15:0] uu [4];
    logic [15:0] xv [4];
    logic [15:0] kv [4];
    logic [15:0] s, r, acc;
    for (int i = 0; i < 4; i++) uu[i] = uv[i*16 +: 16];
    for (int i = 0; i < 16; i++) mp[i] = fm(lam, mp[i]);
    for (int rr = 0; rr < 4; rr++) begin
      xv[rr] = 16'h0;
      for (int c = 0; c < 4; c++) xv[rr] = xv[rr] + fm(mp[rr*4+c], uu[c]);
    end
    s = 16'h0;
    for (int i = 0; i < 4; i++) s = s + fm(uu[i], xv[i]);
    r = rcp(s + 16'h0400);
    for (int i = 0; i < 4; i++) kv[i] = fm(xv[i], r);
    acc = 16'h0;
    for (int i = 0; i < 4; i++) acc = acc + fm(mw[i], uu[i]);
    al = dv - acc;
    for (int i = 0; i < 4; i++) mw[i] = mw[i] + fm(kv[i], al);
    for (int rr = 0; rr < 4; rr++)
      for (int c = 0; c < 4; c++)
        mp[rr*4+c] = mp[rr*4+c] - fm(kv[rr], xv[c]);
  endtask

  task automatic run_iter(input logic [63:0] uv, input logic [15:0] dv, input logic poke);
    logic [15:0] al;
    int n;
    int busy_seen;
    model(uv, dv, lam_inv_i, al);
    u_i     = uv;
    d_i     = dv;
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    chk("R6 busy after start", {15'h0, busy_o}, 16'h0001);
    n = 0;
    while (!done_o && n < 400) begin
      if (poke && (n == 20 || n == 60)) begin
        start_i = 1'b1;
        u_i     = ~uv;
        d_i     = ~dv;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    if (poke) begin
      // R7: a request during the done cycle is dropped as well
      start_i = 1'b1;
    end
    chk("R6 done reached", {15'h0, done_o}, 16'h0001);
    for (int i = 0; i < 4; i++) chk("R4 weight", w_o[i*16 +: 16], mw[i]);
    chk("R4 alpha", alpha_o, al);
    @(negedge clk);
    start_i = 1'b0;
    chk("R6 done one cycle", {15'h0, done_o}, 16'h0000);
    chk("R6 idle after done", {15'h0, busy_o}, 16'h0000);
    if (poke) begin
      busy_seen = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (busy_o) busy_seen++;
      end
      chk("R7 no extra update", busy_seen[15:0], 16'h0000);
      for (int i = 0; i < 4; i++) chk("R8 weight held", w_o[i*16 +: 16], mw[i]);
      chk("R8 alpha held", alpha_o, al);
    end
  endtask

  initial begin
    logic [15:0] tw [4];
    logic [15:0] dv;
    logic [63:0] uv;
    n_chk     = 0;
    n_err     = 0;
    seed      = 32'h1234_5678;
    rst_n     = 1'b0;
    init_i    = 1'b0;
    start_i   = 1'b0;
    lam_inv_i = 16'h0400;
    dlt_inv_i = 16'h0400;
    u_i       = '0;
    d_i       = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {15'h0, busy_o}, 16'h0000);
    chk("R1 done", {15'h0, done_o}, 16'h0000);
    for (int i = 0; i < 4; i++) chk("R1 weight", w_o[i*16 +: 16], 16'h0000);
    chk("R1 alpha", alpha_o, 16'h0000);

    // R4/R5 hand-computed case: den = 2.0 so r = 0.5, w0 = 0.5
    lam_inv_i = 16'h0400;
    do_init(16'h0400, 1'b0);
    run_iter({48'h0, 16'h0400}, 16'h0400, 1'b0);
    chk("R5 w0 for den 2.0", w_o[15:0], 16'h0200);
    chk("R4 alpha for first update", alpha_o, 16'h0400);

    // R5 zero denominator: P = -1.0*I, u = (1,0,0,0) gives den 0, r = 0x7FFF
    do_init(16'hFC00, 1'b0);
    run_iter({48'h0, 16'h0400}, 16'h0200, 1'b0);
    chk("R5 w0 for zero den", w_o[15:0], 16'hC000);
    chk("R5 w1 for zero den", w_o[31:16], 16'h0000);

    // R9: init and start together, init wins (checked inside do_init)
    do_init(16'h0800, 1'b1);

    // R3/R4 sweep over several forgetting factors and regularisations
    tw[0] = 16'h0CCD; tw[1] = 16'h0466; tw[2] = 16'hF79A; tw[3] = 16'h02CD;
    for (int cfg = 0; cfg < 4; cfg++) begin
      case (cfg)
        0: begin lam_inv_i = 16'h0400; do_init(16'h0400, 1'b0); end
        1: begin lam_inv_i = 16'h0435; do_init(16'h1000, 1'b0); end
        2: begin lam_inv_i = 16'h040A; do_init(16'h2800, 1'b0); end
        default: begin lam_inv_i = 16'h0420; do_init(16'h0100, 1'b0); end
      endcase
      for (int it = 0; it < 24; it++) begin
        for (int i = 0; i < 4; i++) begin
          seed = xs(seed);
          uv[i*16 +: 16] = {{4{seed[11]}}, seed[11:0]};
        end
        dv = 16'h0;
        for (int i = 0; i < 4; i++) dv = dv + fm(tw[i], uv[i*16 +: 16]);
        seed = xs(seed);
        dv = dv + {{12{seed[3]}}, seed[3:0]};
        // R7/R8 exercised on a few iterations
        run_iter(uv, dv, (it % 8) == 3);
      end
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule